// File: doc/BRIEF.md
# Command-Driven Random Number Engine with Automatic Reseeding

This block is a register-mapped random number engine that software steers by writing command codes. A generate command has the engine produce a fresh block of output words, 128 or 256 bits depending on a mode bit. A reseed command refreshes the internal generator state. Completion is reported through sticky status flags. Software clears these flags by writing ones to them, and they can raise an interrupt line.

A programmable reseed threshold makes the engine reseed itself once enough output has been produced, counted in 16-byte units. A read-only identification register returns a fixed code. After reset the engine runs one power-on seeding pass, which raises the ready flag once before any command is issued. The entropy source and the conditioning stage are modelled by a deterministic mixing generator.

Top module: `trng_cmd_top`

## Requirements
- R1: After reset the engine runs a power-on seeding pass of SEED_CYCLES clock edges. During the pass the command register (0x00) reads 2, and status (0x14) reads 0. At the end of the pass, status bit 0 (ready) sets and bit 1 (seed-done) stays clear.
- R2: Writing 1 to the command register while idle makes the engine busy for GEN_CYCLES edges, with the command register reading 1. Status bit 0 becomes visible after the GEN_CYCLES-th edge, the output words are refreshed on that same edge, and the command register then reads 0.
- R3: Writing 2 to the command register while idle makes the engine busy for SEED_CYCLES edges, with the command register reading 2. Status bit 1 then sets, and the output words at 0x20–0x3C do not change.
- R4: Bit 3 of the mode register (0x08) selects the output size. With 0, a generate refreshes only words 0–3 (0x20–0x2C) and words 4–7 hold their values. With 1, all eight words are refreshed.
- R5: A command written while the engine is busy is ignored. A written code other than 1 or 2 starts nothing.
- R6: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged. A flag that sets on the same edge as its clear stays set.
- R7: The interrupt enable register is at 0x10, with bit 31 as the global enable, bit 1 for seed-done and bit 0 for ready. `irq` equals bit 31 AND ((status0 AND bit0) OR (status1 AND bit1)).
- R8: The reseed count register is at 0x60. Each generate adds 1 unit (128-bit mode) or 2 units (256-bit mode) to an accumulator. When the count is nonzero and the accumulator reaches it, a reseed of SEED_CYCLES edges follows the generate directly: the command register reads 2, seed-done then sets, and the accumulator clears. A count of 0 disables automatic reseeding.
- R9: The version register at 0xF0 reads 0x000046BC, and unmapped addresses read 0. The mode register reads back only bit 3, the enable register only bits 31, 1 and 0, and the reseed count register all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 8 | Byte address of the register write |
| wrData | input | 32 | Register write data |
| rdAddr | input | 8 | Byte address of the register read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| irq | output | 1 | Level interrupt |

## Verification
Reads are combinational, and a register write takes effect on the edge that captures it. Each flag therefore has a fixed due edge, counted from the capture edge of the command: ready becomes visible GEN_CYCLES edges later, seed-done SEED_CYCLES edges later, and seed-done after an automatic reseed GEN_CYCLES+SEED_CYCLES edges later. The bench drives on falling edges and samples each flag one edge before its due edge, expecting it still clear, and again on the due edge, expecting it set. It also times a status clear to land on the exact edge on which ready sets, and a second command to land inside a busy window.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_IE     = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_STAT   = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_RESEED = 8'h60;
  localparam logic [ADDR_W-1:0] ADDR_VER    = 8'hF0;
  localparam logic [2:0]        WORD_WIN    = 3'b001;  // 0x20..0x3F

  localparam logic [DATA_W-1:0] VERSION_ID = 32'h0000_46BC;
  localparam logic [DATA_W-1:0] CMD_NOP    = 32'd0;
  localparam logic [DATA_W-1:0] CMD_GEN    = 32'd1;
  localparam logic [DATA_W-1:0] CMD_SEED   = 32'd2;

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_GEN, ST_SEED} engState_e;

  typedef struct packed {
    logic genPulse;   // refresh output words this edge
    logic wide;       // 256-bit output
    logic seedPulse;  // refresh generator state this edge
  } dpStrobe_t;
endpackage

// File: rtl/trng_ctrl.sv
module trng_ctrl
  import trng_pkg::*;
#(
  parameter int GEN_CYCLES  = 8,
  parameter int SEED_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] ctrlRdData,
  output logic              irq,
  output dpStrobe_t         strobe
);
  localparam int MAX_CYC = (GEN_CYCLES > SEED_CYCLES) ? GEN_CYCLES : SEED_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] GEN_LOAD  = CNT_W'(GEN_CYCLES - 1);
  localparam logic [CNT_W-1:0] SEED_LOAD = CNT_W'(SEED_CYCLES - 1);

  engState_e         stateQ;
  logic [CNT_W-1:0]  cntQ;
  logic [1:0]        statusQ;    // {seedDone, ready}
  logic [2:0]        ieQ;        // {global, seedDone, ready}
  logic              wideQ;
  logic [DATA_W-1:0] reseedCntQ;
  logic [DATA_W-1:0] unitsQ;
  logic [DATA_W:0]   unitsSum;

  logic cmdWrite, startGen, startSeed, genFinish, seedFinish, initFinish, reseedDue;
  logic statWrite;

  assign cmdWrite   = wrEn && (wrAddr == ADDR_CMD);
  assign statWrite  = wrEn && (wrAddr == ADDR_STAT);
  assign startGen   = (stateQ == ST_IDLE) && cmdWrite && (wrData == CMD_GEN);
  assign startSeed  = (stateQ == ST_IDLE) && cmdWrite && (wrData == CMD_SEED);
  assign genFinish  = (stateQ == ST_GEN)  && (cntQ == '0);
  assign seedFinish = (stateQ == ST_SEED) && (cntQ == '0);
  assign initFinish = (stateQ == ST_INIT) && (cntQ == '0);
  assign unitsSum   = {1'b0, unitsQ} + (wideQ ? (DATA_W+1)'(2) : (DATA_W+1)'(1));
  assign reseedDue  = (reseedCntQ != '0) && (unitsSum >= {1'b0, reseedCntQ});

  // Sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_INIT;
      cntQ   <= SEED_LOAD;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startGen) begin
            stateQ <= ST_GEN;
            cntQ   <= GEN_LOAD;
          end else if (startSeed) begin
            stateQ <= ST_SEED;
            cntQ   <= SEED_LOAD;
          end
        end
        ST_GEN: begin
          if (cntQ != '0) cntQ <= cntQ - 1'b1;
          else if (reseedDue) begin
            stateQ <= ST_SEED;
            cntQ   <= SEED_LOAD;
          end else stateQ <= ST_IDLE;
        end
        default: begin  // ST_INIT, ST_SEED
          if (cntQ != '0) cntQ <= cntQ - 1'b1;
          else stateQ <= ST_IDLE;
        end
      endcase
    end
  end

  // Output accounting for automatic reseed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unitsQ <= '0;
    else if (genFinish) begin
      if (reseedCntQ == '0 || reseedDue) unitsQ <= '0;
      else unitsQ <= unitsSum[DATA_W-1:0];
    end
  end

  // Sticky status, write-one-to-clear; a set on the same edge wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else begin
      statusQ[0] <= (genFinish || initFinish) || (statusQ[0] && !(statWrite && wrData[0]));
      statusQ[1] <= seedFinish || (statusQ[1] && !(statWrite && wrData[1]));
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ        <= '0;
      wideQ      <= 1'b0;
      reseedCntQ <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_IE)     ieQ        <= {wrData[31], wrData[1:0]};
      if (wrAddr == ADDR_MODE)   wideQ      <= wrData[3];
      if (wrAddr == ADDR_RESEED) reseedCntQ <= wrData;
    end
  end

  assign irq = ieQ[2] && ((statusQ[0] && ieQ[0]) || (statusQ[1] && ieQ[1]));

  assign strobe.genPulse  = genFinish;
  assign strobe.wide      = wideQ;
  assign strobe.seedPulse = seedFinish || initFinish;

  always_comb begin
    unique case (rdAddr)
      ADDR_CMD: begin
        unique case (stateQ)
          ST_GEN:           ctrlRdData = CMD_GEN;
          ST_SEED, ST_INIT: ctrlRdData = CMD_SEED;
          default:          ctrlRdData = CMD_NOP;
        endcase
      end
      ADDR_MODE:   ctrlRdData = {28'd0, wideQ, 3'd0};
      ADDR_IE:     ctrlRdData = {ieQ[2], 29'd0, ieQ[1:0]};
      ADDR_STAT:   ctrlRdData = {30'd0, statusQ};
      ADDR_RESEED: ctrlRdData = reseedCntQ;
      ADDR_VER:    ctrlRdData = VERSION_ID;
      default:     ctrlRdData = '0;
    endcase
  end

  // Assertions
  assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && wrData[0] && !genFinish && !initFinish) |=> !statusQ[0]);

  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GEN && cntQ != '0 && cmdWrite) |=> (stateQ == ST_GEN));

  assert_gen_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    genFinish |=> statusQ[0]);

  assert_auto_reseed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (genFinish && reseedDue) |=> (stateQ == ST_SEED && unitsQ == '0));

  assert_seed_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    seedFinish |=> (statusQ[1] && stateQ == ST_IDLE));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.genPulse, strobe.seedPulse}));
endmodule

// File: rtl/trng_datapath.sv
module trng_datapath
  import trng_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] wordRdData
);
  localparam int HALF  = NUM_WORDS / 2;
  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam logic [DATA_W-1:0] STATE_INIT = 32'h1F2E_3D4C;
  localparam logic [DATA_W-1:0] GOLDEN     = 32'h9E37_79B9;

  function automatic logic [DATA_W-1:0] mixWord(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    y = x ^ (x >> 16);
    y = y * 32'h7FEB_352D;
    y = y ^ (y >> 15);
    y = y * 32'h846C_A68B;
    return y ^ (y >> 16);
  endfunction

  function automatic logic [DATA_W-1:0] stepState(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  logic [DATA_W-1:0] genStateQ, entropyQ, reseedVal;
  logic [DATA_W-1:0] wordQ  [NUM_WORDS];
  logic [DATA_W-1:0] freshW [NUM_WORDS];
  logic [NUM_WORDS-1:0] refreshEn;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    assign freshW[i]    = mixWord(genStateQ ^ (DATA_W'(i + 1) * GOLDEN));
    assign refreshEn[i] = strobe.genPulse && (strobe.wide || (i < HALF));
  end

  assign reseedVal = stepState(genStateQ ^ mixWord(entropyQ));

  // Free-running stand-in for the entropy source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) entropyQ <= '0;
    else       entropyQ <= entropyQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) genStateQ <= STATE_INIT;
    else if (strobe.seedPulse) genStateQ <= (reseedVal == '0) ? STATE_INIT : reseedVal;
    else if (strobe.genPulse)  genStateQ <= stepState(genStateQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) wordQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_WORDS; i++)
        if (refreshEn[i]) wordQ[i] <= freshW[i];
    end
  end

  assign wordRdData = wordQ[rdAddr[2 +: IDX_W]];

  assert_half_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.genPulse && !strobe.wide) |=> $stable(wordQ[NUM_WORDS-1]));

  assert_seed_keeps_words_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seedPulse |=> $stable(wordQ[0]));
endmodule

// File: rtl/trng_cmd_top.sv
module trng_cmd_top
  import trng_pkg::*;
#(
  parameter int GEN_CYCLES  = 8,
  parameter int SEED_CYCLES = 12,
  parameter int NUM_WORDS   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [7:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irq
);
  dpStrobe_t         strobe;
  logic [DATA_W-1:0] ctrlRdData, wordRdData;

  trng_ctrl #(.GEN_CYCLES(GEN_CYCLES), .SEED_CYCLES(SEED_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .ctrlRdData(ctrlRdData), .irq(irq), .strobe(strobe)
  );

  trng_datapath #(.NUM_WORDS(NUM_WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .wordRdData(wordRdData)
  );

  assign rdData = (rdAddr[7:5] == WORD_WIN) ? wordRdData : ctrlRdData;
endmodule

// File: tb/trng_cmd_top_tb_top.sv
`timescale 1ns/10ps
module trng_cmd_top_tb_top;
  localparam int G = 8;
  localparam int S = 12;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, irq;
  logic [7:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  int checks = 0, errors = 0;
  logic [31:0] snap [8];

  always #2 clk = ~clk;  // 250 MHz

  trng_cmd_top #(.GEN_CYCLES(G), .SEED_CYCLES(S), .NUM_WORDS(8)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq));

  typedef struct packed {
    logic        doWrite;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expRd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hF0, 32'h0,          32'h0000_46BC},
    '{1'b0, 8'h04, 32'h0,          32'h0},
    '{1'b1, 8'h08, 32'hFFFF_FFFF,  32'h0000_0008},
    '{1'b1, 8'h08, 32'h0000_0000,  32'h0},
    '{1'b1, 8'h10, 32'hFFFF_FFFF,  32'h8000_0003},
    '{1'b1, 8'h10, 32'h0,          32'h0},
    '{1'b1, 8'h60, 32'hA5A5_0005,  32'hA5A5_0005},
    '{1'b1, 8'h60, 32'h0,          32'h0},
    '{1'b1, 8'hF0, 32'h1234_5678,  32'h0000_46BC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.05;
    d = rdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic snapWords();
    for (int i = 0; i < 8; i++) rd(8'h20 + 8'(4 * i), snap[i]);
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int changed;
    // R1: reset and power-on seeding
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(S - 1);
    rd(8'h14, d); chk("R1 status during init", d, 32'h0);
    rd(8'h00, d); chk("R1 cmd reads seeding", d, 32'd2);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    waitEdges(1);
    rd(8'h14, d); chk("R1 ready after init", d, 32'h1);
    rd(8'h00, d); chk("R1 cmd idle", d, 32'd0);

    // R9: register vector table
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].doWrite) wr(VECS[v].addr, VECS[v].wdata);
      rd(VECS[v].addr, d);
      chk($sformatf("R9 vector %0d", v), d, VECS[v].expRd);
    end

    // R6: write zero keeps, write one clears
    wr(8'h14, 32'h0); rd(8'h14, d); chk("R6 write zero keeps", d, 32'h1);
    wr(8'h14, 32'h1); rd(8'h14, d); chk("R6 write one clears", d, 32'h0);

    // R2 / R4: 256-bit generate
    wr(8'h08, 32'h8);
    snapWords();
    wr(8'h00, 32'd1);
    waitEdges(G - 1);
    rd(8'h14, d); chk("R2 ready not early", d, 32'h0);
    rd(8'h00, d); chk("R2 cmd busy gen", d, 32'd1);
    waitEdges(1);
    rd(8'h14, d); chk("R2 ready on time", d, 32'h1);
    rd(8'h00, d); chk("R2 cmd idle after", d, 32'd0);
    changed = 0;
    for (int i = 0; i < 8; i++) begin rd(8'h20 + 8'(4 * i), d); if (d != snap[i]) changed++; end
    chk("R4 wide refreshes eight", 32'(changed), 32'd8);

    // R4: 128-bit generate; R6 set wins over same-edge clear
    wr(8'h14, 32'h3);
    wr(8'h08, 32'h0);
    snapWords();
    wr(8'h00, 32'd1);
    waitEdges(G - 2);
    wr(8'h14, 32'h1);  // captured on the finishing edge
    rd(8'h14, d); chk("R6 set wins same edge", d, 32'h1);
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(4 * i), d);
      if (i < 4) chk($sformatf("R4 narrow lower word %0d changes", i), {31'd0, d != snap[i]}, 32'd1);
      else       chk($sformatf("R4 narrow upper word %0d holds", i), d, snap[i]);
    end

    // R5: command while busy, and an unknown code while idle
    wr(8'h14, 32'h3);
    wr(8'h00, 32'd1);
    wr(8'h00, 32'd2);
    waitEdges(G - 2);
    rd(8'h14, d); chk("R5 gen still completes", d, 32'h1);
    waitEdges(S + 2);
    rd(8'h14, d); chk("R5 busy seed ignored", d, 32'h1);
    wr(8'h14, 32'h3);
    wr(8'h00, 32'd3);
    rd(8'h00, d); chk("R5 unknown code idle", d, 32'd0);
    waitEdges(S + G);
    rd(8'h14, d); chk("R5 unknown code no flag", d, 32'h0);

    // R3: commanded reseed
    snapWords();
    wr(8'h00, 32'd2);
    waitEdges(S - 1);
    rd(8'h14, d); chk("R3 seed-done not early", d, 32'h0);
    rd(8'h00, d); chk("R3 cmd busy seed", d, 32'd2);
    waitEdges(1);
    rd(8'h14, d); chk("R3 seed-done on time", d, 32'h2);
    changed = 0;
    for (int i = 0; i < 8; i++) begin rd(8'h20 + 8'(4 * i), d); if (d != snap[i]) changed++; end
    chk("R3 words untouched", 32'(changed), 32'd0);

    // R7: interrupt combination (status = seed-done only)
    wr(8'h10, 32'h0000_0002); chk("R7 no global", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h8000_0001); chk("R7 ready disabled src", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h8000_0002); chk("R7 seed-done enabled", {31'd0, irq}, 32'd1);
    wr(8'h14, 32'h2);         chk("R7 cleared low", {31'd0, irq}, 32'd0);
    wr(8'h10, 32'h8000_0001);
    wr(8'h00, 32'd1);
    waitEdges(G);
    chk("R7 ready enabled", {31'd0, irq}, 32'd1);
    wr(8'h10, 32'h0); wr(8'h14, 32'h3);

    // R8: automatic reseed, 256-bit mode, count 3
    wr(8'h08, 32'h8);
    wr(8'h60, 32'd3);
    wr(8'h00, 32'd1);
    waitEdges(G);
    rd(8'h00, d); chk("R8 first gen below count", d, 32'd0);
    waitEdges(S);
    rd(8'h14, d); chk("R8 no reseed yet", d, 32'h1);
    wr(8'h14, 32'h3);
    wr(8'h00, 32'd1);
    waitEdges(G);
    rd(8'h14, d); chk("R8 ready before reseed", d, 32'h1);
    rd(8'h00, d); chk("R8 auto reseed busy", d, 32'd2);
    waitEdges(S - 1);
    rd(8'h14, d); chk("R8 seed-done not early", d, 32'h1);
    waitEdges(1);
    rd(8'h14, d); chk("R8 seed-done on time", d, 32'h3);
    wr(8'h14, 32'h3);
    wr(8'h00, 32'd1);
    waitEdges(G + S);
    rd(8'h14, d); chk("R8 accumulator cleared", d, 32'h1);
    // R8: 128-bit mode, count 1 reseeds after every generate
    wr(8'h14, 32'h3);
    wr(8'h08, 32'h0);
    wr(8'h60, 32'd1);
    wr(8'h00, 32'd1);
    waitEdges(G + S);
    rd(8'h14, d); chk("R8 narrow count one", d, 32'h3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule